// File: doc/BRIEF.md
# Multicycle Instruction Phase Sequencer

This block steps a non-pipelined 32-bit processor through the phases of each instruction. The phases are fetch, decode/operand read, execute/address, memory/branch completion, and result write-back. The block holds the current phase and produces one-cycle write strobes for the instruction register, the next-PC temporary, the program counter and the register file. The block contains the program counter, the next-PC temporary and the instruction register. Other datapath units use these registers and the phase output directly.

An external decoder looks at the instruction register and supplies a two-bit instruction class. The sequencer captures this class during decode and uses it to choose the exit point. Stores and branches stop after the memory/branch phase. ALU operations and loads continue to write-back. A memory-ready handshake keeps the sequencer in fetch, or in a memory phase that does a data access, until the memory responds. The PC changes only when the memory/branch phase completes, and register results are committed only in write-back.

Top module: `phase_seq`

## Requirements
- R1: While reset is active and after it is released, the phase is fetch (code 0), and pc and ir read 0. The reset is asynchronous and active-low, and its release is synchronised over two clock edges.
- R2: In fetch (phase code 0), mem_req is high. When mem_ready is low, the phase holds. When mem_ready is high, ir_we and npc_we are both high in that cycle, ir takes fetch_word at the edge, and the next phase is decode (code 1).
- R3: At every fetch, the next-PC temporary takes pc + 4. A PC update that is not a taken branch writes that value.
- R4: pc_we is high only in the memory/branch phase (code 3), for its completing cycle. pc does not change in any other cycle.
- R5: rf_we is high only in write-back (code 4), for one cycle.
- R6: ir keeps the fetched word through every later phase of the same instruction, and changes only at a fetch edge.
- R7: An ALU instruction (class 0) goes through phases 0,1,2,3,4. Its memory phase lasts one cycle, has mem_req low and no wait for mem_ready, and still updates pc.
- R8: A load (class 1) goes through phases 0,1,2,3,4. Its memory phase keeps mem_req high and holds until mem_ready is high.
- R9: A store (class 2) goes through phases 0,1,2,3 and then returns to fetch. Its memory phase keeps mem_req high and holds until mem_ready is high.
- R10: A branch (class 3) goes through phases 0,1,2,3 and then returns to fetch without a memory wait. pc becomes target_addr if take_branch is high in the completing cycle, and pc + 4 otherwise. take_branch has no effect for any other class.
- R11: The class is sampled only in decode. Changes on instr_class during later phases have no effect on the sequence.
- R12: mem_req is high in fetch and in the memory phase of loads and stores, and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_class | input | 2 | Instruction class from the decoder: 0 ALU, 1 load, 2 store, 3 branch |
| mem_ready | input | 1 | Memory access completes this cycle |
| take_branch | input | 1 | Branch condition outcome |
| fetch_word | input | 32 | Instruction word read from instruction memory |
| target_addr | input | 32 | Computed branch target |
| phase | output | 3 | Current phase: 0 fetch, 1 decode, 2 execute, 3 memory/branch, 4 write-back |
| mem_req | output | 1 | A memory access is in progress this cycle |
| ir_we | output | 1 | Instruction register write strobe |
| npc_we | output | 1 | Next-PC temporary write strobe |
| pc_we | output | 1 | Program counter write strobe |
| rf_we | output | 1 | Register-file write strobe |
| pc | output | 32 | Program counter |
| ir | output | 32 | Instruction register |

## Verification
The assertions assume that mem_ready is meaningful only when mem_req is high. They also assume that instr_class is valid in the decode cycle. Nothing is assumed about take_branch or target_addr outside a branch completion.

The stimulus keeps mem_ready low in every cycle that is not an intended completion. It drives a valid class in decode and deliberately drives different classes in execute and memory. It holds take_branch high during ALU instructions so that any leak of the branch outcome into the PC shows up.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    PH_IF  = 3'd0,
    PH_ID  = 3'd1,
    PH_EX  = 3'd2,
    PH_MEM = 3'd3,
    PH_WB  = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    CL_ALU    = 2'd0,
    CL_LOAD   = 2'd1,
    CL_STORE  = 2'd2,
    CL_BRANCH = 2'd3
  } iclass_e;

  typedef struct packed {
    logic ir_we;
    logic npc_we;
    logic pc_we;
    logic rf_we;
  } strobe_t;

endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/seq_phase_fsm.sv
module seq_phase_fsm
  import seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    instr_class,
  input  logic          mem_ready,
  output phase_e        phase,
  output strobe_t       stb,
  output logic          mem_req,
  output logic          is_branch
);

  phase_e  ph_q, ph_d;
  iclass_e cls_q;
  logic    cls_en;
  logic    uses_mem;
  logic    ends_early;

  assign uses_mem   = (cls_q == CL_LOAD) || (cls_q == CL_STORE);
  assign ends_early = (cls_q == CL_STORE) || (cls_q == CL_BRANCH);
  assign cls_en     = (ph_q == PH_ID);

  always_comb begin
    ph_d    = ph_q;
    stb     = '0;
    mem_req = 1'b0;
    case (ph_q)
      PH_IF: begin
        mem_req = 1'b1;
        if (mem_ready) begin
          stb.ir_we  = 1'b1;
          stb.npc_we = 1'b1;
          ph_d       = PH_ID;
        end
      end
      PH_ID: ph_d = PH_EX;
      PH_EX: ph_d = PH_MEM;
      PH_MEM: begin
        mem_req = uses_mem;
        if (!uses_mem || mem_ready) begin
          stb.pc_we = 1'b1;
          ph_d      = ends_early ? PH_IF : PH_WB;
        end
      end
      PH_WB: begin
        stb.rf_we = 1'b1;
        ph_d      = PH_IF;
      end
      default: ph_d = PH_IF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IF;
    else        ph_q <= ph_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cls_q <= CL_ALU;
    else if (cls_en) cls_q <= iclass_e'(instr_class);
  end

  assign phase     = ph_q;
  assign is_branch = (cls_q == CL_BRANCH);

  // R2: fetch waits for memory, then moves on to decode
  a_r2_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IF && !mem_ready) |=> (ph_q == PH_IF));
  a_r2_fetch_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IF && mem_ready) |=> (ph_q == PH_ID));
  // R4: PC strobe is confined to the memory/branch phase
  a_r4_pc_we_in_mem: assert property (@(posedge clk) disable iff (!rst_n)
    stb.pc_we |-> (ph_q == PH_MEM));
  // R5: register-file strobe is confined to write-back
  a_r5_rf_we_in_wb: assert property (@(posedge clk) disable iff (!rst_n)
    stb.rf_we |-> (ph_q == PH_WB));
  // R9: a completing store or branch returns straight to fetch
  a_r9_early_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.pc_we && ends_early) |=> (ph_q == PH_IF));
  // R7: decode is always followed by execute, then memory
  a_r7_decode_order: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_ID) |=> (ph_q == PH_EX));
  a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.ir_we, stb.pc_we, stb.rf_we}));

endmodule

// File: rtl/seq_arch_regs.sv
module seq_arch_regs #(
  parameter int          XLEN     = 32,
  parameter int          PC_STEP  = 4,
  parameter logic [31:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ir_we,
  input  logic            npc_we,
  input  logic            pc_we,
  input  logic            take_target,
  input  logic [XLEN-1:0] fetch_word,
  input  logic [XLEN-1:0] target_addr,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] ir
);

  localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);
  localparam logic [XLEN-1:0] PC0  = XLEN'(RESET_PC);

  logic [XLEN-1:0] pc_q, pc_d;
  logic [XLEN-1:0] npc_q, npc_d;
  logic [XLEN-1:0] ir_q;

  always_comb begin
    npc_d = pc_q + STEP;
    pc_d  = take_target ? target_addr : npc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= PC0;
    else if (pc_we) pc_q <= pc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      npc_q <= '0;
    else if (npc_we) npc_q <= npc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ir_q <= '0;
    else if (ir_we) ir_q <= fetch_word;
  end

  assign pc = pc_q;
  assign ir = ir_q;

  // R6: instruction register only moves on a fetch strobe
  a_r6_ir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_we |=> $stable(ir_q));
  // R4: PC only moves on its strobe
  a_r4_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_we |=> $stable(pc_q));
  // R3: next-PC temporary steps from the fetched PC
  a_r3_npc_step: assert property (@(posedge clk) disable iff (!rst_n)
    npc_we |=> (npc_q == $past(pc_q) + STEP));

endmodule

// File: rtl/phase_seq.sv
module phase_seq
  import seq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      instr_class,
  input  logic            mem_ready,
  input  logic            take_branch,
  input  logic [XLEN-1:0] fetch_word,
  input  logic [XLEN-1:0] target_addr,
  output logic [2:0]      phase,
  output logic            mem_req,
  output logic            ir_we,
  output logic            npc_we,
  output logic            pc_we,
  output logic            rf_we,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] ir
);

  logic    rst_int_n;
  phase_e  ph;
  strobe_t stb;
  logic    is_branch;

  seq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  seq_phase_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .instr_class (instr_class),
    .mem_ready   (mem_ready),
    .phase       (ph),
    .stb         (stb),
    .mem_req     (mem_req),
    .is_branch   (is_branch)
  );

  seq_arch_regs #(.XLEN(XLEN)) u_regs (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .ir_we       (stb.ir_we),
    .npc_we      (stb.npc_we),
    .pc_we       (stb.pc_we),
    .take_target (is_branch && take_branch),
    .fetch_word  (fetch_word),
    .target_addr (target_addr),
    .pc          (pc),
    .ir          (ir)
  );

  assign phase  = ph;
  assign ir_we  = stb.ir_we;
  assign npc_we = stb.npc_we;
  assign pc_we  = stb.pc_we;
  assign rf_we  = stb.rf_we;

endmodule

// File: tb/tb_phase_seq.sv
module tb_phase_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  instr_class;
  logic        mem_ready;
  logic        take_branch;
  logic [31:0] fetch_word;
  logic [31:0] target_addr;
  logic [2:0]  phase;
  logic        mem_req, ir_we, npc_we, pc_we, rf_we;
  logic [31:0] pc, ir;

  int ntests = 0;
  int nfail  = 0;

  typedef struct {
    logic [2:0]  ph;
    logic [3:0]  stb;
    logic        req;
    logic [31:0] pc;
    logic [31:0] ir;
    bit          chk_ir;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  logic [31:0] mpc;

  always #4 clk = ~clk;

  phase_seq dut (
    .clk(clk), .rst_n(rst_n), .instr_class(instr_class), .mem_ready(mem_ready),
    .take_branch(take_branch), .fetch_word(fetch_word), .target_addr(target_addr),
    .phase(phase), .mem_req(mem_req), .ir_we(ir_we), .npc_we(npc_we),
    .pc_we(pc_we), .rf_we(rf_we), .pc(pc), .ir(ir)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    ntests++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor: one expected item per cycle, compared mid-cycle
  always @(negedge clk) begin : monitor
    exp_t e;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      chk({e.tag, " R11 phase"}, 32'(phase), 32'(e.ph));
      chk("R2 ir_we/npc_we", 32'({ir_we, npc_we}), 32'(e.stb[3:2]));
      chk("R4 pc_we", 32'(pc_we), 32'(e.stb[1]));
      chk("R5 rf_we", 32'(rf_we), 32'(e.stb[0]));
      chk("R12 mem_req", 32'(mem_req), 32'(e.req));
      chk("R3 R10 pc", pc, e.pc);
      if (e.chk_ir) chk("R6 ir", ir, e.ir);
    end
  end

  task automatic push(logic [2:0] ph, logic [3:0] s, logic req, logic [31:0] irv,
                      bit ci, string tag);
    exp_t e;
    e.ph = ph; e.stb = s; e.req = req; e.pc = mpc; e.ir = irv; e.chk_ir = ci; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  // driver: one instruction, with chosen wait counts
  task automatic run(logic [1:0] cls, logic [31:0] w, int ifw, int memw,
                     logic take, logic [31:0] tgt);
    string t;
    bit uses, wb;
    case (cls)
      2'd0: t = "R7";
      2'd1: t = "R8";
      2'd2: t = "R9";
      default: t = "R10";
    endcase
    uses = (cls == 2'd1) || (cls == 2'd2);
    wb   = (cls == 2'd0) || (cls == 2'd1);
    for (int i = 0; i < ifw; i++) begin
      cyc(); mem_ready = 1'b0; instr_class = cls + 2'd1;
      push(3'd0, 4'b0000, 1'b1, '0, 1'b0, t);
    end
    cyc(); mem_ready = 1'b1; fetch_word = w;
    push(3'd0, 4'b1100, 1'b1, '0, 1'b0, t);
    cyc(); mem_ready = 1'b0; fetch_word = ~w; instr_class = cls;
    push(3'd1, 4'b0000, 1'b0, w, 1'b1, t);
    cyc(); instr_class = cls ^ 2'b11; take_branch = 1'b1; target_addr = ~tgt;
    push(3'd2, 4'b0000, 1'b0, w, 1'b1, t);
    if (uses) begin
      for (int i = 0; i < memw; i++) begin
        cyc(); mem_ready = 1'b0; instr_class = cls ^ 2'b01;
        push(3'd3, 4'b0000, 1'b1, w, 1'b1, t);
      end
    end
    cyc(); mem_ready = uses ? 1'b1 : 1'b0; take_branch = take; target_addr = tgt;
    push(3'd3, 4'b0010, uses, w, 1'b1, t);
    mpc = (cls == 2'd3 && take) ? tgt : mpc + 32'd4;
    if (wb) begin
      cyc(); mem_ready = 1'b0; take_branch = 1'b1;
      push(3'd4, 4'b0001, 1'b0, w, 1'b1, t);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0; mem_ready = 1'b0; instr_class = 2'd0; take_branch = 1'b0;
    fetch_word = '0; target_addr = '0; mpc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 phase in reset", 32'(phase), 32'd0);
    chk("R1 pc in reset", pc, 32'd0);
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 phase after release", 32'(phase), 32'd0);
    chk("R1 pc after release", pc, 32'd0);
    chk("R1 ir after release", ir, 32'd0);
    chk("R1 strobes idle", 32'({ir_we, npc_we, pc_we, rf_we}), 32'd0);

    run(2'd0, 32'h1111_0001, 0, 0, 1'b1, 32'h0000_0800); // ALU, branch outcome ignored
    run(2'd1, 32'h2222_0002, 2, 3, 1'b0, 32'h0);         // load with waits
    run(2'd2, 32'h3333_0003, 1, 2, 1'b1, 32'h0000_0400); // store with waits
    run(2'd3, 32'h4444_0004, 0, 0, 1'b0, 32'h0000_0200); // branch not taken
    run(2'd3, 32'h5555_0005, 3, 0, 1'b1, 32'h0000_0100); // branch taken
    run(2'd0, 32'h6666_0006, 1, 0, 1'b0, 32'h0);         // ALU after redirect
    run(2'd1, 32'h7777_0007, 0, 0, 1'b1, 32'hFFFF_0000); // load, no wait
    run(2'd2, 32'h8888_0008, 0, 0, 1'b0, 32'h0);         // store, no wait
    run(2'd3, 32'h9999_0009, 0, 0, 1'b1, 32'h0000_0040); // back-to-back taken

    cyc(); mem_ready = 1'b0;
    push(3'd0, 4'b0000, 1'b1, '0, 1'b0, "R2");
    cyc();
    push(3'd0, 4'b0000, 1'b1, '0, 1'b0, "R2");
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R6 queue drained", 32'(exp_q.size()), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

endmodule